// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a system clock into the nominal bit timing of a CAN node. A programmable divider makes time-quantum ticks from the clock. Each bit is then built from quanta: one synchronization quantum, a first timing segment that ends at the sample point, and a second timing segment that ends the bit. At the sample point the block pulses a sample strobe and captures the receive line. When a new bit begins, it pulses a bit-start strobe. Framing and bit-level protocol logic sit downstream and use these two strobes.

The block follows the transmitter's clock through falling edges on the receive line, which it takes as already synchronized to the clock. While the bus is idle, a falling edge restarts the bit at once. This is a hard synchronization. During a frame, an edge that arrives late lengthens the first segment. An edge that arrives early shortens the second segment. Both corrections are capped by a programmable jump width, and at most one correction is made per bit. Each configuration field is encoded as its value minus one. A configuration that breaks the timing rules raises an error flag and holds the timing logic in its reset state.

Top module: `can_bit_timer`

## Requirements
- R1: The quantum length is P = cfg_presc + 1 clocks, so the 8-bit field 0..255 divides the clock by 1 to 256.
- R2: When the receive line has no falling edges, bit_start_stb pulses once every P*(1+T1+T2) clocks, where T1 = cfg_ts1 + 1 and T2 = cfg_ts2 + 1. sample_stb pulses P*(1+T1) clocks after each bit_start_stb, which places the sample point at the end of segment 1 after a single synchronization quantum.
- R3: sample_bit holds the value rx_in had on the clock edge that raised sample_stb, and keeps it until the next sample. A 1 is recessive and a 0 is dominant.
- R4: cfg_err is high, with no clock delay, whenever any of these holds: T1 < 2; T2 > T1 - 1; J > T1 - 1, where J = cfg_sjw + 1 (1..4); or 1+T1+T2 is outside 8..25. While cfg_err is high, neither strobe pulses. T1=16, T2=8, J=4 is legal.
- R5: When cfg_err falls, the timing restarts at the synchronization quantum. If cfg_err clears before clock edge m+1, the first bit_start_stb follows that edge by P*(1+T1+T2) - 1 clocks.
- R6: A falling edge is rx_in at 1 on one clock edge and at 0 on the next. While bus_idle is 1, a falling edge seen on clock edge E restarts the bit: bit_start_stb is high after E, and the sample follows P*(1+T1) clocks later.
- R7: When bus_idle is 0, a falling edge in quantum k of segment 1 (k = 0 is the first quantum) lengthens segment 1 by min(k+1, J) quanta. This delays both the sample and the next bit start.
- R8: When bus_idle is 0, a falling edge in quantum j of segment 2 has error T2 - j. If the error is at most J, a new bit starts at once, with bit_start_stb high after that edge. Otherwise the bit is cut short by J quanta.
- R9: At most one resynchronization happens per bit. A falling edge in the synchronization quantum and any rising edge have no effect on timing.
- R10: No resynchronization happens while the last sampled bit is dominant (sample_bit = 0).
- R11: After reset, both strobes are low and sample_bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_presc | input | 8 | Quantum divider minus one |
| cfg_ts1 | input | 4 | Segment 1 length in quanta minus one |
| cfg_ts2 | input | 3 | Segment 2 length in quanta minus one |
| cfg_sjw | input | 2 | Jump width in quanta minus one |
| rx_in | input | 1 | Synchronized receive line, 1 = recessive |
| bus_idle | input | 1 | High while no frame is in progress; selects hard synchronization |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Receive value captured at the last sample point |
| bit_start_stb | output | 1 | One-clock pulse when a bit begins |
| cfg_err | output | 1 | Configuration breaks the timing rules |

## Verification
The bench places falling edges at random quanta and random clock offsets inside a bit. Edges land in the synchronization quantum, in segment 1, and in segment 2 on both sides of the jump-width limit. A design that measured the phase error off by one quantum, or that did not cap the error at the jump width, would move the sample or the bit start by whole quanta. Directed cases check the following:
- A second edge in the same bit: a design that resynchronizes twice lengthens the bit again.
- An edge after a dominant sample: a design that ignores the last sampled bit shifts the sample.
- The largest divider setting.
- Each configuration-legality boundary: a design that tests a limit with the wrong inequality shows a wrong cfg_err or stray strobes.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_cfgchk.sv
module can_bt_cfgchk #(
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int SJW_W   = 2,
  parameter int SUM_W   = 6,
  parameter int BIT_MIN = 8,
  parameter int BIT_MAX = 25
) (
  input  logic [TS1_W-1:0] cfg_ts1,
  input  logic [TS2_W-1:0] cfg_ts2,
  input  logic [SJW_W-1:0] cfg_sjw,
  output logic [SUM_W-1:0] t1_len,
  output logic [SUM_W-1:0] t2_len,
  output logic [SUM_W-1:0] sjw_len,
  output logic             err
);
  logic [SUM_W-1:0] total;

  // Lengths in quanta: each field is stored as its value minus one.
  always_comb begin
    t1_len  = SUM_W'(cfg_ts1) + SUM_W'(1);
    t2_len  = SUM_W'(cfg_ts2) + SUM_W'(1);
    sjw_len = SUM_W'(cfg_sjw) + SUM_W'(1);
    total   = t1_len + t2_len + SUM_W'(1);
    err     = (t1_len < SUM_W'(2))
            | (t2_len >= t1_len)
            | (sjw_len >= t1_len)
            | (total < SUM_W'(BIT_MIN))
            | (total > SUM_W'(BIT_MAX));
  end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               restart,
  input  logic [PRESC_W-1:0] div,
  output logic               tick
);
  logic [PRESC_W-1:0] pc_q, pc_d;

  // A >= compare lets the count recover at once if div is lowered mid-count.
  always_comb begin
    tick = ~hold & (pc_q >= div);
    if (hold || restart || tick) pc_d = '0;
    else                         pc_d = pc_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R1
  pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !$past(hold) && $stable(div)) |-> (pc_q <= div));

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div != '0) |=> (!tick || div == '0 || !$stable(div)));
endmodule

// File: rtl/can_bt_segctr.sv
module can_bt_segctr
  import can_bt_pkg::*;
#(
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             rx_in,
  input  logic             bus_idle,
  input  logic [SUM_W-1:0] t1_len,
  input  logic [SUM_W-1:0] t2_len,
  input  logic [SUM_W-1:0] sjw_len,
  output logic             restart,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start_stb
);
  seg_e             seg_q, seg_d;
  logic [SUM_W-1:0] cnt_q, cnt_d, lim_q, lim_d, lim_eff;
  logic [SUM_W-1:0] err_one, adj, remain;
  logic             done_q, done_d, rxp_q;
  logic             ss_q, ss_d, bs_q, bs_d, sb_q, sb_d;
  logic             fall, hard, rs_ok, jump_now;

  // Edge detection and phase-error evaluation
  always_comb begin
    fall     = rxp_q & ~rx_in;
    hard     = fall & bus_idle;
    rs_ok    = fall & ~bus_idle & ~done_q & sb_q;
    err_one  = cnt_q + SUM_W'(1);
    adj      = (err_one < sjw_len) ? err_one : sjw_len;
    remain   = lim_q - cnt_q;
    jump_now = rs_ok && (seg_q == SEG_TWO) && (remain <= sjw_len);
    restart  = ~hold & (hard | jump_now);
    lim_eff  = lim_q;
    if (rs_ok && seg_q == SEG_ONE)
      lim_eff = lim_q + adj;
    else if (rs_ok && seg_q == SEG_TWO && !jump_now)
      lim_eff = lim_q - sjw_len;
  end

  // Next-state logic
  always_comb begin
    seg_d  = seg_q;
    cnt_d  = cnt_q;
    lim_d  = lim_eff;
    done_d = done_q;
    ss_d   = 1'b0;
    bs_d   = 1'b0;
    sb_d   = sb_q;
    if (rs_ok && seg_q != SEG_SYNC) done_d = 1'b1;
    if (hold) begin
      seg_d  = SEG_SYNC;
      cnt_d  = '0;
      lim_d  = '0;
      done_d = 1'b0;
      sb_d   = 1'b1;
    end else if (restart) begin
      seg_d  = SEG_SYNC;
      cnt_d  = '0;
      bs_d   = 1'b1;
      done_d = 1'b1;
    end else if (tick) begin
      unique case (seg_q)
        SEG_SYNC: begin
          seg_d = SEG_ONE;
          cnt_d = '0;
          lim_d = t1_len;
        end
        SEG_ONE: begin
          if (cnt_q == lim_eff - SUM_W'(1)) begin
            seg_d = SEG_TWO;
            cnt_d = '0;
            lim_d = t2_len;
            ss_d  = 1'b1;
            sb_d  = rx_in;
          end else begin
            cnt_d = cnt_q + SUM_W'(1);
          end
        end
        SEG_TWO: begin
          if (cnt_q == lim_eff - SUM_W'(1)) begin
            seg_d  = SEG_SYNC;
            cnt_d  = '0;
            bs_d   = 1'b1;
            done_d = 1'b0;
          end else begin
            cnt_d = cnt_q + SUM_W'(1);
          end
        end
        default: seg_d = SEG_SYNC;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
      rxp_q  <= 1'b1;
      ss_q   <= 1'b0;
      bs_q   <= 1'b0;
      sb_q   <= 1'b1;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      done_q <= done_d;
      rxp_q  <= rx_in;
      ss_q   <= ss_d;
      bs_q   <= bs_d;
      sb_q   <= sb_d;
    end
  end

  assign sample_stb    = ss_q;
  assign bit_start_stb = bs_q;
  assign sample_bit    = sb_q;

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!sample_stb && !bit_start_stb));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start_stb));

  // R2
  seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q != SEG_SYNC) |-> (cnt_q < lim_q));

  // R9
  one_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_ONE && $past(seg_q) == SEG_ONE && lim_q != $past(lim_q))
      |-> !$past(done_q));

  // R10
  dom_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_ONE && $past(seg_q) == SEG_ONE && lim_q != $past(lim_q))
      |-> $past(sb_q));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRESC_W = 8,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int SJW_W   = 2,
  parameter int BIT_MIN = 8,
  parameter int BIT_MAX = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic [TS1_W-1:0]   cfg_ts1,
  input  logic [TS2_W-1:0]   cfg_ts2,
  input  logic [SJW_W-1:0]   cfg_sjw,
  input  logic               rx_in,
  input  logic               bus_idle,
  output logic               sample_stb,
  output logic               sample_bit,
  output logic               bit_start_stb,
  output logic               cfg_err
);
  localparam int SUM_W = TS1_W + 2;

  logic [SUM_W-1:0] t1_len, t2_len, sjw_len;
  logic             tick, restart;

  can_bt_cfgchk #(
    .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W), .SUM_W(SUM_W),
    .BIT_MIN(BIT_MIN), .BIT_MAX(BIT_MAX)
  ) u_cfg (
    .cfg_ts1(cfg_ts1), .cfg_ts2(cfg_ts2), .cfg_sjw(cfg_sjw),
    .t1_len(t1_len), .t2_len(t2_len), .sjw_len(sjw_len), .err(cfg_err)
  );

  can_bt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .hold(cfg_err), .restart(restart),
    .div(cfg_presc), .tick(tick)
  );

  can_bt_segctr #(.SUM_W(SUM_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .hold(cfg_err), .tick(tick),
    .rx_in(rx_in), .bus_idle(bus_idle),
    .t1_len(t1_len), .t2_len(t2_len), .sjw_len(sjw_len),
    .restart(restart), .sample_stb(sample_stb), .sample_bit(sample_bit),
    .bit_start_stb(bit_start_stb)
  );
endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_presc;
  logic [3:0] cfg_ts1;
  logic [2:0] cfg_ts2;
  logic [1:0] cfg_sjw;
  logic       rx_in, bus_idle;
  logic       sample_stb, sample_bit, bit_start_stb, cfg_err;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int P, T1, T2, SJ, N;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_ts1(cfg_ts1),
    .cfg_ts2(cfg_ts2), .cfg_sjw(cfg_sjw), .rx_in(rx_in), .bus_idle(bus_idle),
    .sample_stb(sample_stb), .sample_bit(sample_bit),
    .bit_start_stb(bit_start_stb), .cfg_err(cfg_err)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit legal(input int t1, input int t2, input int sj);
    return (t1 >= 2) && (t2 >= 1) && (t2 <= t1 - 1) && (sj >= 1) && (sj <= 4)
        && (sj <= t1 - 1) && (1 + t1 + t2 >= 8) && (1 + t1 + t2 <= 25);
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic set_cfg(input int p, input int t1, input int t2, input int sj);
    P = p; T1 = t1; T2 = t2; SJ = sj; N = 1 + t1 + t2;
    cfg_presc = 8'(p - 1);
    cfg_ts1   = 4'(t1 - 1);
    cfg_ts2   = 3'(t2 - 1);
    cfg_sjw   = 2'(sj - 1);
  endtask

  task automatic wait_bs(output int c);
    int k = 0;
    do begin @(negedge clk); k++; end while (!bit_start_stb && k < 30000);
    c = bit_start_stb ? cyc : -1;
  endtask

  task automatic wait_ss(output int c, output int b);
    int k = 0;
    do begin @(negedge clk); k++; end while (!sample_stb && k < 30000);
    c = sample_stb ? cyc : -1;
    b = int'(sample_bit);
  endtask

  task automatic go_to(input int m);
    while (cyc < m) @(negedge clk);
  endtask

  // Hard sync, then one clean recessive bit; returns the last bit-start cycle.
  task automatic hsync(output int n);
    int m, c, b;
    rx_in = 1'b1; bus_idle = 1'b1;
    repeat (3) @(negedge clk);
    m = cyc; rx_in = 1'b0;
    wait_bs(c);   chk_eq("R6 hard sync bit start", c, m + 1);
    bus_idle = 1'b0;
    wait_ss(c, b); chk_eq("R6 sample after hard sync", c, m + 1 + P * (1 + T1));
    chk_eq("R3 dominant sample", b, 0);
    rx_in = 1'b1;
    wait_bs(c);   chk_eq("R2 bit period", c, m + 1 + P * N);
    m = c;
    wait_ss(c, b); chk_eq("R2 sample offset", c, m + P * (1 + T1));
    chk_eq("R3 recessive sample", b, 1);
    wait_bs(c);   chk_eq("R2 bit period", c, m + P * N);
    n = c;
  endtask

  // One edge at a random place in a bit, then a clean bit.
  task automatic trial(inout int n);
    int q, r, m, c, b, adj, j, rem, ex;
    q = int'($urandom_range(N - 1, 0));
    r = int'($urandom_range(P - 1, 0));
    m = n + P * q + r;
    if (q > T1) begin
      wait_ss(c, b); chk_eq("R2 sample offset", c, n + P * (1 + T1));
      chk_eq("R3 recessive sample", b, 1);
    end
    go_to(m); rx_in = 1'b0;
    if (q == 0) begin
      wait_ss(c, b); chk_eq("R9 sync-quantum edge no effect", c, n + P * (1 + T1));
      chk_eq("R3 dominant sample", b, 0);
      wait_bs(c);   chk_eq("R9 sync-quantum edge bit length", c, n + P * N);
    end else if (q <= T1) begin
      adj = min2(q, SJ);
      wait_ss(c, b); chk_eq("R7 late edge sample shift", c, n + P * (1 + T1 + adj));
      chk_eq("R3 dominant sample", b, 0);
      wait_bs(c);   chk_eq("R7 late edge bit length", c, n + P * (N + adj));
    end else begin
      j = q - 1 - T1; rem = T2 - j;
      ex = (rem <= SJ) ? m + 1 : n + P * (N - SJ);
      wait_bs(c);   chk_eq("R8 early edge bit end", c, ex);
    end
    rx_in = 1'b1;
    m = c;
    wait_ss(c, b); chk_eq("R2 sample offset", c, m + P * (1 + T1));
    chk_eq("R3 recessive sample", b, 1);
    wait_bs(c);   chk_eq("R2 bit period", c, m + P * N);
    n = c;
  endtask

  initial begin
    int n, c, b, m, s;
    int p, t1, t2, sj;
    void'($urandom(32'd5813));
    rst_n = 1'b0; rx_in = 1'b1; bus_idle = 1'b1;
    set_cfg(2, 8, 4, 2);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk_eq("R11 sample_stb in reset", int'(sample_stb), 0);
    chk_eq("R11 bit_start_stb in reset", int'(bit_start_stb), 0);
    chk_eq("R11 sample_bit in reset", int'(sample_bit), 1);
    chk_eq("R4 legal cfg no error", int'(cfg_err), 0);
    rst_n = 1'b1;

    // R1 largest divider
    set_cfg(256, 4, 3, 2);
    hsync(n);
    wait_bs(c); chk_eq("R1 divide by 256 bit period", c, n + 256 * 8);

    // R4 illegal settings
    set_cfg(2, 1, 1, 1); #1 chk_eq("R4 segment 1 too short", int'(cfg_err), 1);
    set_cfg(2, 4, 2, 1); #1 chk_eq("R4 total below 8", int'(cfg_err), 1);
    set_cfg(2, 5, 5, 2); #1 chk_eq("R4 segment 2 too long", int'(cfg_err), 1);
    set_cfg(2, 4, 3, 4); #1 chk_eq("R4 jump width too wide", int'(cfg_err), 1);
    s = 0;
    repeat (200) begin
      @(negedge clk);
      s += int'(sample_stb) + int'(bit_start_stb);
    end
    chk_eq("R4 no strobes while illegal", s, 0);
    set_cfg(1, 16, 8, 4); #1 chk_eq("R4 total 25 legal", int'(cfg_err), 0);
    set_cfg(2, 1, 1, 1);
    @(negedge clk);
    set_cfg(2, 4, 3, 3); m = cyc;
    #1 chk_eq("R4 total 8 legal", int'(cfg_err), 0);
    wait_bs(c); chk_eq("R5 restart after error clears", c, m + P * N);

    // R9 second edge in the same bit is ignored
    set_cfg(4, 8, 4, 3);
    hsync(n);
    go_to(n + 4); rx_in = 1'b0;
    go_to(n + 6); rx_in = 1'b1;
    go_to(n + 24); rx_in = 1'b0;
    wait_ss(c, b); chk_eq("R9 one resync per bit sample", c, n + 40);
    wait_bs(c);   chk_eq("R9 one resync per bit length", c, n + 56);
    // R10 previous sample dominant blocks resync
    rx_in = 1'b1; m = c;
    go_to(m + 12); rx_in = 1'b0;
    wait_ss(c, b); chk_eq("R10 no resync after dominant sample", c, m + 36);
    wait_bs(c);   chk_eq("R10 bit length unchanged", c, m + 52);
    rx_in = 1'b1;

    // Random configurations and edge placements
    repeat (6) begin
      do begin
        p  = int'($urandom_range(8, 1));
        t1 = int'($urandom_range(16, 2));
        t2 = int'($urandom_range(8, 1));
        sj = int'($urandom_range(4, 1));
      end while (!legal(t1, t2, sj));
      set_cfg(p, t1, t2, sj);
      hsync(n);
      repeat (6) trial(n);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule